// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transceiver

This block is a memory-mapped serial transceiver for a small 8-bit processor bus. Each character on the line carries a start bit, eight data bits sent least significant bit first, a ninth bit chosen by software, and a stop bit. The line rests high. Software can use the ninth bit as an address mark, an extra data bit or a parity bit. Hardware does not compute parity, so software works out that bit when it wants parity.

Software sees two byte registers. The control/status register sits at 0xD7. It holds:
- the receive-ready and transmit-empty flags;
- the two interrupt enables;
- a three-bit baud code;
- the shared ninth bit. A write sets the ninth bit for the next character sent. A read returns the ninth bit of the last character received.

The data register, at 0xD6 by default, starts a transmission when written and returns the last received byte when read.

The register bus is plain: reads are combinational and have no side effects, and writes complete in one cycle. There is no valid/ready back-pressure. A data write that arrives while a character is still being sent is dropped, and software learns that the transmitter is free from the transmit-empty flag. An interrupt request combines both flags with their enables.

Top module: `uart9`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, `tx_o` is high and `irq_o` is low.
- R2: A data write while idle sends one frame on `tx_o`: a low start bit, then bits 0..7 of the written byte, then the ninth bit (control bit 0 as last written), then a high stop bit. Each bit lasts 16*2^code clock cycles.
- R3: The transmit-empty flag (control bit 6) clears on an accepted data write and sets when the stop bit ends. Writing 0 to bit 6 clears it, and writing 1 sets it.
- R4: A data write while a frame is in progress is ignored: no second frame follows, and the frame in progress is unchanged.
- R5: The receiver samples `rx_i` 16 times per bit and takes the majority of samples 7, 8 and 9. A one-sample disturbance inside a bit does not change the result. On a complete frame, the byte appears at the data address, the ninth bit appears at control bit 0, and receive-ready (control bit 7) sets.
- R6: A low pulse on `rx_i` shorter than half a bit is rejected as a false start: receive-ready stays clear.
- R7: Receive-ready is cleared by writing 0 to control bit 7 and set by writing 1, so software can force a receive interrupt.
- R8: `irq_o` = (bit7 & bit5) | (bit6 & bit4), where bit 5 enables the receive interrupt and bit 4 enables the transmit interrupt.
- R9: Control bits 3..1 hold the baud code n. A new code takes effect at once, giving an oversample tick every 2^n clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line, idles high |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 16 samples per bit, a three-bit baud code, and control and data addresses 0xD7 and 0xD6. At baud code 0 every clock is a sample, so a one-cycle spike driven onto the receive line hits exactly one vote sample. That makes the majority vote and the false-start rejection observable. Switching to code 2 at run time covers the divider path, with 64-cycle bits in both directions.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int CHAR_W  = 9;           // eight data bits plus the ninth bit
  localparam int FRAME_W = CHAR_W + 2;  // start + character + stop

  // control register bit positions (software decodes these)
  localparam int B_RXRDY = 7;
  localparam int B_TXMT  = 6;
  localparam int B_RXIEN = 5;
  localparam int B_TXIEN = 4;
  localparam int B_BRHI  = 3;
  localparam int B_BRLO  = 1;
  localparam int B_NINTH = 0;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart9_baud.sv
module uart9_baud #(
  parameter int BR_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BR_W-1:0] code_i,
  output logic            tick_o
);
  localparam int CNT_W = (1 << BR_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   limit;

  assign span   = (CNT_W+1)'(1) << code_i;
  assign limit  = span - (CNT_W+1)'(1);
  // compare with >= so a smaller code mid-count still ticks at once
  assign tick_o = ({1'b0, cnt_q} >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_FAST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == '0) |-> tick_o); // R9
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && code_i != '0) |=> (!tick_o || code_i == '0)); // R9
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tx_o
);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q;
  logic [SUB_W-1:0]   sub_q;
  logic [BIT_W-1:0]   bit_q;

  assign tx_o = sh_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      sub_q  <= '0;
      bit_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i && !busy_o) begin
        sh_q   <= {1'b1, char_i, 1'b0};
        sub_q  <= '0;
        bit_q  <= '0;
        busy_o <= 1'b1;
      end else if (busy_o && tick_i) begin
        sub_q <= sub_q + 1'b1;
        if (sub_q == SUB_W'(OVERSAMPLE - 1)) begin
          sh_q <= {1'b1, sh_q[FRAME_W-1:1]};
          if (bit_q == BIT_W'(FRAME_W - 1)) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_o); // R2
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !tx_o); // R2
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o); // R4
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              done_o,
  output logic [CHAR_W-1:0] char_o
);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(CHAR_W);
  localparam logic [SUB_W-1:0] S_A = SUB_W'(OVERSAMPLE / 2 - 1);
  localparam logic [SUB_W-1:0] S_B = SUB_W'(OVERSAMPLE / 2);
  localparam logic [SUB_W-1:0] S_C = SUB_W'(OVERSAMPLE / 2 + 1);
  localparam logic [SUB_W-1:0] S_END = SUB_W'(OVERSAMPLE - 1);

  rx_state_t         st_q;
  logic [1:0]        sync_q;
  logic              rx_s;
  logic              samp_a, samp_b, vote;
  logic [SUB_W-1:0]  sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CHAR_W-1:0] sh_q;

  assign rx_s = sync_q[1];
  assign vote = maj3(samp_a, samp_b, rx_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      samp_a <= 1'b1;
      samp_b <= 1'b1;
      done_o <= 1'b0;
      char_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        if (st_q == RX_IDLE) begin
          if (!rx_s) begin
            st_q  <= RX_START;
            sub_q <= SUB_W'(1);   // detecting tick is sample 0
          end
        end else begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == S_A) samp_a <= rx_s;
          if (sub_q == S_B) samp_b <= rx_s;
          if (sub_q == S_C) begin
            unique case (st_q)
              RX_START: if (vote) st_q <= RX_IDLE;   // false start
              RX_DATA:  sh_q <= {vote, sh_q[CHAR_W-1:1]};
              RX_STOP: begin
                done_o <= 1'b1;
                char_o <= sh_q;
                st_q   <= RX_IDLE;
              end
              default: ;
            endcase
          end
          if (sub_q == S_END) begin
            if (st_q == RX_START) begin
              st_q  <= RX_DATA;
              idx_q <= '0;
            end else if (st_q == RX_DATA) begin
              if (idx_q == IDX_W'(CHAR_W - 1)) st_q <= RX_STOP;
              else                             idx_q <= idx_q + 1'b1;
            end
          end
        end
      end
    end
  end

  AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5
  AST_RX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (st_q == RX_IDLE)); // R5
endmodule

// File: rtl/uart9.sv
module uart9
  import uart9_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  CTRL_ADDR  = 8'hD7,
  parameter logic [7:0]  DATA_ADDR  = 8'hD6,
  parameter int          OVERSAMPLE = 16,
  parameter int          BR_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              irq_o
);
  logic            rxrdy_q, txmt_q, rxien_q, txien_q;
  logic [BR_W-1:0] code_q;
  logic            ninth_tx_q, ninth_rx_q;
  logic [7:0]      rx_byte_q;

  logic              tick, tx_busy, tx_done, rx_done;
  logic [CHAR_W-1:0] rx_char;
  logic              ctrl_wr, data_wr, tx_load;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign data_wr = bus_wr && (bus_addr == ADDR_W'(DATA_ADDR));
  assign tx_load = data_wr && !tx_busy;

  uart9_baud #(.BR_W(BR_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .code_i(code_q), .tick_o(tick));

  uart9_tx #(.OVERSAMPLE(OVERSAMPLE)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(tx_load),
    .char_i({ninth_tx_q, bus_wdata}), .busy_o(tx_busy),
    .done_o(tx_done), .tx_o(tx_o));

  uart9_rx #(.OVERSAMPLE(OVERSAMPLE)) rx_i_u (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_i),
    .done_o(rx_done), .char_o(rx_char));

  // hardware events take priority over a software write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxrdy_q    <= 1'b0;
      txmt_q     <= 1'b0;
      rxien_q    <= 1'b0;
      txien_q    <= 1'b0;
      code_q     <= '0;
      ninth_tx_q <= 1'b0;
      ninth_rx_q <= 1'b0;
      rx_byte_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        rxrdy_q    <= bus_wdata[B_RXRDY];
        txmt_q     <= bus_wdata[B_TXMT];
        rxien_q    <= bus_wdata[B_RXIEN];
        txien_q    <= bus_wdata[B_TXIEN];
        code_q     <= bus_wdata[B_BRHI:B_BRLO];
        ninth_tx_q <= bus_wdata[B_NINTH];
      end
      if (tx_load) txmt_q <= 1'b0;
      if (tx_done) txmt_q <= 1'b1;
      if (rx_done) begin
        rxrdy_q    <= 1'b1;
        rx_byte_q  <= rx_char[7:0];
        ninth_rx_q <= rx_char[CHAR_W-1];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
      bus_rdata[B_RXRDY]         = rxrdy_q;
      bus_rdata[B_TXMT]          = txmt_q;
      bus_rdata[B_RXIEN]         = rxien_q;
      bus_rdata[B_TXIEN]         = txien_q;
      bus_rdata[B_BRHI:B_BRLO]   = code_q;
      bus_rdata[B_NINTH]         = ninth_rx_q;
    end else if (bus_addr == ADDR_W'(DATA_ADDR)) begin
      bus_rdata = rx_byte_q;
    end
  end

  assign irq_o = (rxrdy_q & rxien_q) | (txmt_q & txien_q);

  AST_TXMT_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !txmt_q); // R3
  AST_TXMT_SET_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> txmt_q); // R3
  AST_RXRDY_SET_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rxrdy_q); // R5
  AST_NO_IRQ_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxien_q && !txien_q) |-> !irq_o); // R8
endmodule

// File: tb/uart9_tb_top.sv
module uart9_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rx_i = 1'b1;
  logic       tx_o, irq_o;

  localparam logic [7:0] CA = 8'hD7;
  localparam logic [7:0] DA = 8'hD6;

  int tests = 0, fails = 0, frames_seen = 0, bit_cyc = 16;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  uart9 dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_i(rx_i), .tx_o(tx_o),
    .irq_o(irq_o));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic send_tx(input logic [8:0] c, input logic [7:0] ctrl_rest);
    wr(CA, {ctrl_rest[7:1], c[8]});
    exp_q.push_back(c);
    wr(DA, c[7:0]);
  endtask

  task automatic send_rx(input logic [8:0] c, input int bc, input int spike_bit);
    logic [10:0] fr;
    fr = {1'b1, c, 1'b0};
    for (int i = 0; i < 11; i++)
      for (int k = 0; k < bc; k++) begin
        @(negedge clk);
        rx_i = fr[i] ^ ((i == spike_bit) && (k == bc / 2));
      end
    rx_i = 1'b1;
    repeat (bc) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: decode frames on tx_o and compare with the scoreboard queue
  initial begin
    logic [10:0] got;
    logic [8:0]  exp;
    forever begin
      @(negedge clk);
      if (rst_n && tx_o === 1'b0) begin
        repeat (bit_cyc / 2) @(negedge clk);
        got[0] = tx_o;
        for (int i = 1; i < 11; i++) begin
          repeat (bit_cyc) @(negedge clk);
          got[i] = tx_o;
        end
        frames_seen++;
        if (exp_q.size() == 0) begin
          check("R4 unexpected frame", int'(got), -1);
        end else begin
          exp = exp_q.pop_front();
          check("R2 frame bits", int'(got), int'({1'b1, exp, 1'b0}));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int f0;
    idle(3); rst_n = 1'b1; idle(2);
    // R1 reset state
    rd(CA, v); check("R1 ctrl reset", v, 8'h00);
    rd(DA, v); check("R1 data reset", v, 8'h00);
    check("R1 tx idle", tx_o, 1);
    check("R1 irq reset", irq_o, 0);

    // R2/R3 one frame at code 0, ninth bit 1
    send_tx(9'h1A5, 8'h00);
    rd(CA, v); check("R3 txmt clear after write", v[6], 0);
    check("R5 ninth read is rx side", v[0], 0);
    idle(165); rd(CA, v); check("R3 txmt still clear mid-frame", v[6], 0);
    idle(15);  rd(CA, v); check("R3 txmt set after stop", v[6], 1);
    check("R2 frames seen", frames_seen, 1);

    // R3 software clear/set of txmt, R8 irq from tx side
    wr(CA, 8'h10); rd(CA, v); check("R3 txmt cleared by write 0", v[6], 0);
    check("R8 irq off with flag clear", irq_o, 0);
    wr(CA, 8'h50); check("R8 irq from txmt&txien", irq_o, 1);
    wr(CA, 8'h40); check("R8 irq masked by txien", irq_o, 0);

    // R4 write during frame ignored
    f0 = frames_seen;
    send_tx(9'h03C, 8'h00);
    idle(40); wr(DA, 8'hFF);
    idle(400);
    check("R4 single frame after busy write", frames_seen - f0, 1);
    rd(CA, v); check("R4 txmt set once frame done", v[6], 1);

    // R5 receive with majority vote, code 0
    wr(CA, 8'h00);
    send_rx(9'h15A, 16, -1);
    rd(DA, v); check("R5 rx byte", v, 8'h5A);
    rd(CA, v); check("R5 rxrdy set", v[7], 1); check("R5 rx ninth", v[0], 1);
    wr(CA, 8'h00);
    send_rx(9'h0C3, 16, 3);   // spike in data bit 2
    rd(DA, v); check("R5 spike outvoted", v, 8'hC3);
    rd(CA, v); check("R5 ninth zero", v[0], 0); check("R5 rxrdy again", v[7], 1);

    // R7 software clear and set of rxrdy, R8 irq from rx side
    wr(CA, 8'h20); rd(CA, v); check("R7 rxrdy cleared", v[7], 0);
    check("R8 irq off", irq_o, 0);
    wr(CA, 8'hA0); rd(CA, v); check("R7 rxrdy set by write", v[7], 1);
    check("R8 irq from rxrdy&rxien", irq_o, 1);
    wr(CA, 8'h80); check("R8 irq masked by rxien", irq_o, 0);

    // R6 false start rejected
    wr(CA, 8'h00);
    @(negedge clk); rx_i = 1'b0; idle(3); rx_i = 1'b1;
    idle(300);
    rd(CA, v); check("R6 glitch gives no rxrdy", v[7], 0);
    rd(DA, v); check("R6 data unchanged", v, 8'hC3);

    // R9 code 2: 64-cycle bits both ways
    bit_cyc = 64;
    f0 = frames_seen;
    send_tx(9'h0E7, 8'h04);
    rd(CA, v); check("R9 code readback", v[3:1], 2);
    idle(800);
    check("R9 frame at code 2", frames_seen - f0, 1);
    rd(CA, v); check("R9 txmt after slow frame", v[6], 1);
    wr(CA, 8'h04);
    send_rx(9'h196, 64, -1);
    rd(DA, v); check("R9 rx byte at code 2", v, 8'h96);
    rd(CA, v); check("R9 rx ninth at code 2", v[0], 1);

    check("R2 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule